// File: doc/BRIEF.md
# Configurable Logic Cell with Two Storage Elements

This block is one programmable logic tile. It has two four-input lookup tables, named F and G. Their outputs feed a third, three-input table named H. The third input of H comes from a control line. The table contents are configuration inputs, so any Boolean function of the table inputs can be loaded. All three table results leave the tile directly as combinational outputs, without passing through any register.

Four general control lines feed a configuration crossbar. Each of the four internal control roles takes one of the four lines, chosen by its own 2-bit select. The roles are:

- the third input of H,
- a direct data bit,
- a force (set/reset) strobe,
- a load enable.

The tile has two storage bits, X and Y, and each is configured on its own:

- its data source: F, G, H, or the direct data bit;
- the clock edge it responds to: rising or falling;
- the value the force strobe drives it to.

Top module: `cfg_logic_cell`

## Requirements
- R1: `f_out` equals bit `f_in` of `f_table`. `f_in` is read as an unsigned index, and bit 0 of the table is the entry for index 0.
- R2: `g_out` equals bit `g_in` of `g_table`, indexed in the same way as R1.
- R3: `h_out` equals bit {h1, G, F} of `h_table`. Here h1 is the most significant index bit and F is the least significant. h1 is the control line chosen by `map_h1`.
- R4: Each internal role (h1, data, force, enable) is driven by `ctl_in[sel]`, where sel is that role's 2-bit select. Select values 0 to 3 pick lines C1 to C4, which are bits 0 to 3 of `ctl_in`. Any assignment of roles to lines is allowed, including the same line for several roles.
- R5: A storage bit's source select chooses what it loads: 0 = F, 1 = G, 2 = H, 3 = the direct data bit.
- R6: With its edge bit at 0, a storage bit changes only on the rising edge of `clk`.
- R7: With its edge bit at 1, a storage bit changes only on the falling edge of `clk`.
- R8: When the enable role is low and the force role is low, a storage bit holds its value across its active edge.
- R9: When the force role is high at a storage bit's active edge, the bit takes its configured force value. This happens whatever the enable and the selected data are.
- R10: When `rst` is high at a storage bit's active edge, the bit is cleared to 0. `rst` has priority over force and load.
- R11: X and Y are independent. Different source, edge and force settings apply to each in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock |
| rst | input | 1 | Synchronous active-high clear of both storage bits |
| f_in | input | 4 | Index inputs of table F |
| g_in | input | 4 | Index inputs of table G |
| ctl_in | input | 4 | Control lines C1..C4 (bit 0 = C1) |
| f_table | input | 16 | Contents of table F |
| g_table | input | 16 | Contents of table G |
| h_table | input | 8 | Contents of table H |
| map_h1 | input | 2 | Control line feeding the third H input |
| map_din | input | 2 | Control line used as direct data |
| map_sr | input | 2 | Control line used as force strobe |
| map_en | input | 2 | Control line used as load enable |
| x_src | input | 2 | Data source of X |
| y_src | input | 2 | Data source of Y |
| x_fall | input | 1 | X responds to falling edge when 1 |
| y_fall | input | 1 | Y responds to falling edge when 1 |
| x_srval | input | 1 | Value forced into X by the strobe |
| y_srval | input | 1 | Value forced into Y by the strobe |
| f_out | output | 1 | Combinational F result |
| g_out | output | 1 | Combinational G result |
| h_out | output | 1 | Combinational H result |
| x_q | output | 1 | Storage bit X |
| y_q | output | 1 | Storage bit Y |

## Verification
The bench programs X for rising edges and Y for falling edges. It then samples both bits between the two edges. A swapped or ignored edge select shows up as a bit that moves half a cycle early or late. The H table is swept over all eight index values with asymmetric contents, so a reversed index order reads the wrong entry. A second, permuted control mapping catches a crossbar that is wired to fixed lines. Force is checked with the enable held low, so a design that gates force behind enable keeps the old value instead of the forced one.

// File: rtl/clb_pkg.sv
package clb_pkg;
    localparam int LUT_IN    = 4;
    localparam int LUT_SIZE  = 1 << LUT_IN;
    localparam int H_IN      = 3;
    localparam int H_SIZE    = 1 << H_IN;
    localparam int CTL_N     = 4;
    localparam int CTL_SEL_W = $clog2(CTL_N);
    localparam int FF_N      = 2;

    typedef enum logic [1:0] {
        SRC_F   = 2'd0,
        SRC_G   = 2'd1,
        SRC_H   = 2'd2,
        SRC_DIN = 2'd3
    } src_e;

    typedef struct packed {
        logic [CTL_SEL_W-1:0] h1;
        logic [CTL_SEL_W-1:0] din;
        logic [CTL_SEL_W-1:0] sr;
        logic [CTL_SEL_W-1:0] en;
    } ctl_map_t;

    typedef struct packed {
        logic h1;
        logic din;
        logic sr;
        logic en;
    } ctl_sig_t;

    typedef struct packed {
        src_e src;
        logic fall;
        logic srval;
    } ff_cfg_t;

    typedef struct packed {
        logic f;
        logic g;
        logic h;
    } gen_out_t;

    function automatic logic pick_line(input logic [CTL_N-1:0] lines,
                                       input logic [CTL_SEL_W-1:0] sel);
        return lines[sel];
    endfunction
endpackage

// File: rtl/clb_lut.sv
module clb_lut #(
    parameter int N = 4,
    localparam int SIZE = 1 << N
) (
    input  logic [SIZE-1:0] table_bits,
    input  logic [N-1:0]    idx,
    output logic            y
);
    always_comb begin
        y = table_bits[idx];
    end
endmodule

// File: rtl/clb_ctl_map.sv
module clb_ctl_map
    import clb_pkg::*;
(
    input  logic [CTL_N-1:0] lines,
    input  ctl_map_t         map,
    output ctl_sig_t         sig
);
    always_comb begin
        sig.h1  = pick_line(lines, map.h1);
        sig.din = pick_line(lines, map.din);
        sig.sr  = pick_line(lines, map.sr);
        sig.en  = pick_line(lines, map.en);
    end
endmodule

// File: rtl/clb_storage.sv
module clb_storage
    import clb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ff_cfg_t  cfg,
    input  gen_out_t gen,
    input  logic     din,
    input  logic     sr,
    input  logic     en,
    output logic     q
);
    logic eff_clk;
    logic d_sel;

    // Falling-edge option: clock inverted under the configuration bit
    always_comb begin
        eff_clk = clk ^ cfg.fall;
    end

    always_comb begin
        unique case (cfg.src)
            SRC_F:   d_sel = gen.f;
            SRC_G:   d_sel = gen.g;
            SRC_H:   d_sel = gen.h;
            SRC_DIN: d_sel = din;
            default: d_sel = din;
        endcase
    end

    always_ff @(posedge eff_clk) begin
        if (rst)
            q <= 1'b0;
        else if (sr)
            q <= cfg.srval;
        else if (en)
            q <= d_sel;
    end

    // R10: reset clears on the active edge
    assert_reset_clears_R10: assert property (@(posedge eff_clk)
        rst |=> (q == 1'b0));

    // R9: force wins over enable and data
    assert_force_value_R9: assert property (@(posedge eff_clk) disable iff (rst)
        sr |=> (q == $past(cfg.srval)));

    // R8: idle enable holds the bit
    assert_hold_when_idle_R8: assert property (@(posedge eff_clk) disable iff (rst)
        (!sr && !en) |=> $stable(q));

    // R5: enabled load takes the selected source
    assert_load_selected_R5: assert property (@(posedge eff_clk) disable iff (rst)
        (!sr && en) |=> (q == $past(d_sel)));
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
    import clb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LUT_IN-1:0]    f_in,
    input  logic [LUT_IN-1:0]    g_in,
    input  logic [CTL_N-1:0]     ctl_in,
    input  logic [LUT_SIZE-1:0]  f_table,
    input  logic [LUT_SIZE-1:0]  g_table,
    input  logic [H_SIZE-1:0]    h_table,
    input  logic [CTL_SEL_W-1:0] map_h1,
    input  logic [CTL_SEL_W-1:0] map_din,
    input  logic [CTL_SEL_W-1:0] map_sr,
    input  logic [CTL_SEL_W-1:0] map_en,
    input  logic [1:0]           x_src,
    input  logic [1:0]           y_src,
    input  logic                 x_fall,
    input  logic                 y_fall,
    input  logic                 x_srval,
    input  logic                 y_srval,
    output logic                 f_out,
    output logic                 g_out,
    output logic                 h_out,
    output logic                 x_q,
    output logic                 y_q
);
    ctl_map_t map;
    ctl_sig_t sig;
    gen_out_t gen;
    ff_cfg_t  ff_cfg [FF_N];
    logic     ff_q   [FF_N];

    always_comb begin
        map.h1  = map_h1;
        map.din = map_din;
        map.sr  = map_sr;
        map.en  = map_en;
        ff_cfg[0] = '{src: src_e'(x_src), fall: x_fall, srval: x_srval};
        ff_cfg[1] = '{src: src_e'(y_src), fall: y_fall, srval: y_srval};
    end

    clb_ctl_map u_map (
        .lines (ctl_in),
        .map   (map),
        .sig   (sig)
    );

    clb_lut #(.N(LUT_IN)) u_lut_f (
        .table_bits (f_table),
        .idx        (f_in),
        .y          (gen.f)
    );

    clb_lut #(.N(LUT_IN)) u_lut_g (
        .table_bits (g_table),
        .idx        (g_in),
        .y          (gen.g)
    );

    clb_lut #(.N(H_IN)) u_lut_h (
        .table_bits (h_table),
        .idx        ({sig.h1, gen.g, gen.f}),
        .y          (gen.h)
    );

    for (genvar i = 0; i < FF_N; i++) begin : g_ff
        clb_storage u_ff (
            .clk (clk),
            .rst (rst),
            .cfg (ff_cfg[i]),
            .gen (gen),
            .din (sig.din),
            .sr  (sig.sr),
            .en  (sig.en),
            .q   (ff_q[i])
        );
    end

    always_comb begin
        f_out = gen.f;
        g_out = gen.g;
        h_out = gen.h;
        x_q   = ff_q[0];
        y_q   = ff_q[1];
    end
endmodule

// File: tb/cfg_logic_cell_test.sv
module cfg_logic_cell_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  f_in = '0, g_in = '0, ctl_in = '0;
    logic [15:0] f_table = '0, g_table = '0;
    logic [7:0]  h_table = '0;
    logic [1:0]  map_h1 = 2'd0, map_din = 2'd1, map_sr = 2'd2, map_en = 2'd3;
    logic [1:0]  x_src = 2'd3, y_src = 2'd3;
    logic        x_fall = 1'b0, y_fall = 1'b1;
    logic        x_srval = 1'b1, y_srval = 1'b1;
    logic        f_out, g_out, h_out, x_q, y_q;

    int vectors = 0;
    int errors  = 0;

    cfg_logic_cell uut (.*);

    always #5 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_rise(); @(posedge clk); #2; endtask
    task automatic wait_fall(); @(negedge clk); #2; endtask

    task automatic t_reset();
        rst = 1'b1; ctl_in = 4'b0110;
        wait_rise(); wait_fall(); wait_rise(); wait_fall();
        check("R10 x after reset", x_q, 1'b0);
        check("R10 y after reset", y_q, 1'b0);
        rst = 1'b0; ctl_in = 4'b0000;
    endtask

    task automatic t_lut_fg();
        f_table = 16'h8E31; g_table = 16'h52C7;
        for (int i = 0; i < 16; i++) begin
            f_in = 4'(i); g_in = 4'(15 - i); #1;
            check("R1 f_out", f_out, f_table[i]);
            check("R2 g_out", g_out, g_table[15 - i]);
        end
    endtask

    task automatic t_lut_h();
        f_table = 16'hAAAA; g_table = 16'hCCCC; h_table = 8'hB4;
        for (int i = 0; i < 8; i++) begin
            f_in = {3'b0, i[0]}; g_in = {2'b0, i[1], 1'b0};
            ctl_in = {3'b0, i[2]}; #1;
            check("R3 h_out", h_out, h_table[i]);
        end
        ctl_in = '0;
    endtask

    task automatic t_edges();
        x_src = 2'd3; y_src = 2'd3;
        wait_fall();
        ctl_in = 4'b1010;
        wait_rise();
        check("R6 x rises", x_q, 1'b1);
        check("R7 y waits falling", y_q, 1'b0);
        wait_fall();
        check("R7 y loaded on fall", y_q, 1'b1);
        check("R6 x unchanged at fall", x_q, 1'b1);
    endtask

    task automatic t_sources();
        f_table = 16'hFFFF; g_table = 16'h0000; h_table = 8'h00;
        f_in = '0; g_in = '0;
        x_src = 2'd1; y_src = 2'd0; ctl_in = 4'b1000;
        wait_rise(); wait_fall();
        check("R5 x from G", x_q, 1'b0);
        check("R11 y from F", y_q, 1'b1);
        h_table = 8'h02; x_src = 2'd2;
        wait_rise();
        check("R5 x from H", x_q, 1'b1);
    endtask

    task automatic t_enable();
        x_src = 2'd3; y_src = 2'd3; ctl_in = 4'b0000;
        wait_rise(); wait_fall();
        check("R8 x holds", x_q, 1'b1);
        check("R8 y holds", y_q, 1'b1);
    endtask

    task automatic t_force();
        x_srval = 1'b0; y_srval = 1'b1;
        ctl_in = 4'b0100;
        wait_rise(); wait_fall();
        check("R9 x forced low", x_q, 1'b0);
        check("R11 y forced high", y_q, 1'b1);
        ctl_in = 4'b1110; x_srval = 1'b1;
        wait_rise();
        check("R9 force beats load", x_q, 1'b1);
        ctl_in = 4'b0000;
    endtask

    task automatic t_remap();
        map_h1 = 2'd2; map_din = 2'd3; map_sr = 2'd1; map_en = 2'd0;
        x_src = 2'd3; x_srval = 1'b1;
        ctl_in = 4'b0001;
        wait_rise();
        check("R4 remapped din low", x_q, 1'b0);
        ctl_in = 4'b1001;
        wait_rise();
        check("R4 remapped load", x_q, 1'b1);
        ctl_in = 4'b0000;
        wait_rise();
        check("R4 remapped enable off", x_q, 1'b1);
        ctl_in = 4'b0001;
        wait_rise();
        check("R4 remapped en C1", x_q, 1'b0);
        ctl_in = 4'b0010;
        wait_rise();
        check("R4 remapped force C2", x_q, 1'b1);
        f_table = 16'h0002; g_table = 16'h0000; h_table = 8'h20;
        f_in = 4'd1; g_in = 4'd0; ctl_in = 4'b0100; #1;
        check("R4 remapped h1 C3", h_out, 1'b1);
        ctl_in = 4'b0000;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_lut_fg();
        t_lut_h();
        t_edges();
        t_sources();
        t_enable();
        t_force();
        t_remap();
        rst = 1'b1;
        wait_rise(); wait_fall();
        check("R10 x cleared mid-run", x_q, 1'b0);
        check("R10 y cleared mid-run", y_q, 1'b0);
        summary();
    end
endmodule